// File: doc/BRIEF.md
# Trace Record Buffer Store Engine

This block writes fixed-size trace records into two memory rings. Each ring is described by a small set of management registers. The branch channel turns every taken branch it receives into a 12-byte record. The sampling channel owns a 40-bit event counter. Each time that counter wraps, the channel writes a 40-byte record and then reloads the counter with a programmable value.

Both channels use the same bookkeeping. Each keeps a write index, a hard limit that marks the first byte past its buffer, and an early-warning threshold. When a record lands so that the index sits exactly on the threshold, the channel raises a level interrupt, which gives software time to drain the ring before it fills. A record that would cross the limit is dropped and a sticky overflow flag is set.

Records go out one at a time as 32-bit beats on a valid/ready write port, with byte addresses. Software programs the registers through a one-cycle write strobe. It must finish that programming before it sets either channel's enable bit.

Top module: `trace_store_engine`

## Requirements
- R1: An accepted branch request, while branch storing is enabled and the record fits, produces three beats at index, index+4 and index+8. Their data is the branch source word, then the target word, then zero. The branch index then advances by 12.
- R2: A sampling record is ten beats at index+4k, for k = 0..9, with data equal to k. The sampling index then advances by 40.
- R3: While mem_valid is high and mem_ready is low, the beat's address and data hold. A channel's index changes only in the cycle after its last beat is accepted, or on a register write.
- R4: A record whose end would pass the channel's limit is dropped and writes nothing. Its sticky overflow flag is set. Writing the clear register (code 13) with bit 2 clears the branch flag and bit 3 clears the sampling flag.
- R5: A channel's interrupt rises when a stored record leaves its index equal to its threshold. It stays high until cleared through code 13: bit 0 for branch, bit 1 for sampling.
- R6: pmc_value counts one per pmc_evt pulse. Counter codes are 10 for the low 32 bits and 11 for the high 8 bits. When it wraps from all ones to zero with sampling enabled, one sampling record is requested. Once that record is stored or dropped, pmc_value equals the reload value (code 8 low, code 9 high).
- R7: Control code 12 holds the enables: bit 0 for branch, bit 1 for sampling. With bit 0 clear, branch requests are accepted and discarded with no write and no index change. With bit 1 clear, a wrap only returns the counter to zero, with no record and no reload.
- R8: When a sampling record and a branch request are both waiting, the sampling record is written first. The branch is held until it has been written.
- R9: A base write whose two low address bits are not zero is ignored and sets the sticky cfg_err output. Bit 4 of code 13 clears cfg_err.
- R10: Register codes per channel c (0 branch, 1 sampling) are 4c+0 base, 4c+1 index, 4c+2 limit and 4c+3 threshold. An accepted base write also loads the index with the base.
- R11: After reset, the indices, limits, flags, counter and mem_valid are zero, and br_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register code |
| cfg_wdata | input | 32 | Register write data |
| br_valid | input | 1 | Taken-branch request |
| br_ready | output | 1 | Branch request accepted this cycle |
| br_from | input | 32 | Branch source word |
| br_to | input | 32 | Branch target word |
| pmc_evt | input | 1 | Counter increment pulse |
| pmc_value | output | CNT_W | Current counter value |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Write beat accepted |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Beat data |
| br_irq | output | 1 | Branch threshold interrupt |
| smp_irq | output | 1 | Sampling threshold interrupt |
| br_ovf | output | 1 | Branch ring overflow (sticky) |
| smp_ovf | output | 1 | Sampling ring overflow (sticky) |
| cfg_err | output | 1 | Misaligned base rejected (sticky) |
| br_index | output | 32 | Branch write index |
| smp_index | output | 32 | Sampling write index |

## Verification
The bench fills the branch ring until it sits exactly on its limit, then sends one more request. A design that checked the limit against the start address rather than the record end would write past the buffer. It stalls the port in the middle of a branch record while a counter wrap and a second branch arrive together. A design with the wrong priority or a leaky hold would interleave or reorder the records. It also checks that the interrupt rises exactly on the threshold record, stays up through the following record and drops only when cleared. A misaligned base must leave the index untouched. A disabled channel must produce no beats and, for sampling, no reload.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BEAT_BYTES = DW / 8;
  localparam int BR_REC_BYTES = 12;
  localparam int SMP_REC_BYTES = 40;
  localparam int NCH = 2;
  localparam int CH_BR = 0;
  localparam int CH_SMP = 1;
  localparam int CH_REGS = 4;
  localparam int REG_AW = 4;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] word_t;
  typedef logic [REG_AW-1:0] rcode_t;

  localparam rcode_t RG_RLD_LO = rcode_t'(8);
  localparam rcode_t RG_RLD_HI = rcode_t'(9);
  localparam rcode_t RG_CNT_LO = rcode_t'(10);
  localparam rcode_t RG_CNT_HI = rcode_t'(11);
  localparam rcode_t RG_CTRL   = rcode_t'(12);
  localparam rcode_t RG_CLEAR  = rcode_t'(13);

  // register code of item k (0 base, 1 index, 2 limit, 3 threshold) of channel c
  function automatic rcode_t chan_reg(int c, int k);
    return rcode_t'(CH_REGS * c + k);
  endfunction

  function automatic int unsigned rec_bytes(int c);
    return (c == CH_SMP) ? SMP_REC_BYTES : BR_REC_BYTES;
  endfunction

  // true when nbytes starting at idx end at or before lim
  function automatic logic rec_fits(addr_t idx, addr_t lim, int unsigned nbytes);
    logic [AW:0] stop;
    stop = {1'b0, idx} + (AW+1)'(nbytes);
    return stop <= {1'b0, lim};
  endfunction

  function automatic addr_t beat_addr(addr_t start, int unsigned beat);
    return start + addr_t'(beat * BEAT_BYTES);
  endfunction

  function automatic logic base_aligned(addr_t b);
    return b[1:0] == 2'b00;
  endfunction
endpackage

// File: rtl/trs_chan.sv
module trs_chan
  import trs_pkg::*;
#(
  parameter int unsigned REC_BYTES = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_base,
  input  logic  wr_idx,
  input  logic  wr_lim,
  input  logic  wr_thr,
  input  addr_t wdata,
  input  logic  clr_irq,
  input  logic  clr_ovf,
  input  logic  rec_done,
  input  logic  rec_drop,
  output addr_t idx,
  output addr_t lim,
  output logic  irq,
  output logic  ovf,
  output logic  bad_base
);
  addr_t idx_q, lim_q, thr_q, idx_next;
  logic  irq_q, ovf_q, base_ok, idx_load, hit_thr;

  assign base_ok  = base_aligned(wdata);
  assign bad_base = wr_base && !base_ok;
  assign idx_load = wr_idx || (wr_base && base_ok);
  assign idx_next = idx_q + addr_t'(REC_BYTES);
  assign hit_thr  = rec_done && !idx_load && (idx_next == thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      lim_q <= '0;
      thr_q <= '0;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (idx_load)      idx_q <= wdata;
      else if (rec_done) idx_q <= idx_next;
      if (wr_lim) lim_q <= wdata;
      if (wr_thr) thr_q <= wdata;
      if (hit_thr)      irq_q <= 1'b1;
      else if (clr_irq) irq_q <= 1'b0;
      if (rec_drop)     ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
    end
  end

  assign idx = idx_q;
  assign lim = lim_q;
  assign irq = irq_q;
  assign ovf = ovf_q;

  // R3: index moves only on a finished record or a register write
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_done && !idx_load) |=> $stable(idx_q));
  // R5: interrupt is a level that only a clear removes
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_irq) |=> irq_q);
  // R4: overflow flag is sticky
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);
endmodule

// File: rtl/trs_seq.sv
module trs_seq
  import trs_pkg::*;
#(
  parameter int unsigned BR_BEATS  = 3,
  parameter int unsigned SMP_BEATS = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_br,
  input  logic  start_smp,
  input  addr_t start_addr,
  input  word_t br_from,
  input  word_t br_to,
  input  logic  mem_ready,
  output logic  mem_valid,
  output addr_t mem_addr,
  output word_t mem_wdata,
  output logic  busy,
  output logic  is_smp,
  output logic  done_br,
  output logic  done_smp
);
  localparam int unsigned MAXB = (SMP_BEATS > BR_BEATS) ? SMP_BEATS : BR_BEATS;
  localparam int BW = (MAXB > 1) ? $clog2(MAXB) : 1;

  logic          busy_q, smp_q, accept, last;
  logic [BW-1:0] beat_q, last_beat;
  addr_t         addr_q;
  word_t         from_q, to_q;

  assign last_beat = smp_q ? BW'(SMP_BEATS - 1) : BW'(BR_BEATS - 1);
  assign last      = (beat_q == last_beat);
  assign accept    = busy_q && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      smp_q  <= 1'b0;
      beat_q <= '0;
      addr_q <= '0;
      from_q <= '0;
      to_q   <= '0;
    end else if (!busy_q) begin
      if (start_br || start_smp) begin
        busy_q <= 1'b1;
        smp_q  <= start_smp;
        beat_q <= '0;
        addr_q <= start_addr;
        from_q <= br_from;
        to_q   <= br_to;
      end
    end else if (accept) begin
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + BW'(1);
    end
  end

  always_comb begin
    if (smp_q)                  mem_wdata = word_t'(beat_q);
    else if (beat_q == BW'(0))  mem_wdata = from_q;
    else if (beat_q == BW'(1))  mem_wdata = to_q;
    else                        mem_wdata = '0;
  end

  assign mem_valid = busy_q;
  assign mem_addr  = beat_addr(addr_q, 32'(beat_q));
  assign busy      = busy_q;
  assign is_smp    = smp_q;
  assign done_br   = accept && last && !smp_q;
  assign done_smp  = accept && last && smp_q;

  // R3: a stalled beat keeps address and data
  a_r3_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/trs_pmc.sv
module trs_pmc
  import trs_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             en,
  input  logic             reload,
  input  logic             wr_rld_lo,
  input  logic             wr_rld_hi,
  input  logic             wr_cnt_lo,
  input  logic             wr_cnt_hi,
  input  word_t            wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_req
);
  localparam int HI_W = CNT_W - DW;

  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             wrap;

  assign wrap     = evt && (&cnt_q) && !reload && !wr_cnt_lo && !wr_cnt_hi;
  assign wrap_req = wrap && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_rld_lo) rld_q[DW-1:0]     <= wdata;
      if (wr_rld_hi) rld_q[CNT_W-1:DW] <= wdata[HI_W-1:0];
      if (reload)         cnt_q              <= rld_q;
      else if (wr_cnt_lo) cnt_q[DW-1:0]      <= wdata;
      else if (wr_cnt_hi) cnt_q[CNT_W-1:DW]  <= wdata[HI_W-1:0];
      else if (evt)       cnt_q              <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;

  // R6: a handled sampling record leaves the reload value in the counter
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(rld_q)));
  // R6: a wrap returns the counter to zero
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/trace_store_engine.sv
module trace_store_engine
  import trs_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [DW-1:0]     br_from,
  input  logic [DW-1:0]     br_to,
  input  logic              pmc_evt,
  output logic [CNT_W-1:0]  pmc_value,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              br_irq,
  output logic              smp_irq,
  output logic              br_ovf,
  output logic              smp_ovf,
  output logic              cfg_err,
  output logic [AW-1:0]     br_index,
  output logic [AW-1:0]     smp_index
);
  localparam int unsigned BR_BEATS  = BR_REC_BYTES / BEAT_BYTES;
  localparam int unsigned SMP_BEATS = SMP_REC_BYTES / BEAT_BYTES;

  logic [NCH-1:0] en_q, ch_irq, ch_ovf, ch_bad, ch_done, ch_drop;
  addr_t [NCH-1:0] ch_idx, ch_lim;

  logic  clr_we, ctrl_we, cfg_err_q, smp_pend_q;
  logic  seq_busy, seq_is_smp, done_br, done_smp;
  logic  idle, smp_go, smp_fit, br_fit, br_take;
  logic  start_br, start_smp, br_drop, smp_drop, wrap_req;
  addr_t start_addr;

  assign clr_we  = cfg_we && (cfg_addr == RG_CLEAR);
  assign ctrl_we = cfg_we && (cfg_addr == RG_CTRL);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    trs_chan #(.REC_BYTES(rec_bytes(c))) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (cfg_we && (cfg_addr == chan_reg(c, 0))),
      .wr_idx   (cfg_we && (cfg_addr == chan_reg(c, 1))),
      .wr_lim   (cfg_we && (cfg_addr == chan_reg(c, 2))),
      .wr_thr   (cfg_we && (cfg_addr == chan_reg(c, 3))),
      .wdata    (cfg_wdata),
      .clr_irq  (clr_we && cfg_wdata[c]),
      .clr_ovf  (clr_we && cfg_wdata[NCH + c]),
      .rec_done (ch_done[c]),
      .rec_drop (ch_drop[c]),
      .idx      (ch_idx[c]),
      .lim      (ch_lim[c]),
      .irq      (ch_irq[c]),
      .ovf      (ch_ovf[c]),
      .bad_base (ch_bad[c])
    );
  end

  // one record at a time; a waiting sampling record goes before any branch
  assign idle      = !seq_busy;
  assign smp_go    = idle && smp_pend_q;
  assign smp_fit   = rec_fits(ch_idx[CH_SMP], ch_lim[CH_SMP], SMP_REC_BYTES);
  assign br_fit    = rec_fits(ch_idx[CH_BR], ch_lim[CH_BR], BR_REC_BYTES);
  assign start_smp = smp_go && smp_fit;
  assign smp_drop  = smp_go && !smp_fit;
  assign br_ready  = idle && !smp_pend_q;
  assign br_take   = br_valid && br_ready;
  assign start_br  = br_take && en_q[CH_BR] && br_fit;
  assign br_drop   = br_take && en_q[CH_BR] && !br_fit;
  assign start_addr = start_smp ? ch_idx[CH_SMP] : ch_idx[CH_BR];

  assign ch_done = {done_smp, done_br};
  assign ch_drop = {smp_drop, br_drop};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      cfg_err_q  <= 1'b0;
      smp_pend_q <= 1'b0;
    end else begin
      if (ctrl_we) en_q <= cfg_wdata[NCH-1:0];
      if (|ch_bad)                              cfg_err_q <= 1'b1;
      else if (clr_we && cfg_wdata[2*NCH])      cfg_err_q <= 1'b0;
      if (!en_q[CH_SMP])  smp_pend_q <= 1'b0;
      else if (wrap_req)  smp_pend_q <= 1'b1;
      else if (smp_go)    smp_pend_q <= 1'b0;
    end
  end

  trs_seq #(.BR_BEATS(BR_BEATS), .SMP_BEATS(SMP_BEATS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_br   (start_br),
    .start_smp  (start_smp),
    .start_addr (start_addr),
    .br_from    (br_from),
    .br_to      (br_to),
    .mem_ready  (mem_ready),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (seq_busy),
    .is_smp     (seq_is_smp),
    .done_br    (done_br),
    .done_smp   (done_smp)
  );

  trs_pmc #(.CNT_W(CNT_W)) u_pmc (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (pmc_evt),
    .en        (en_q[CH_SMP]),
    .reload    (done_smp || smp_drop),
    .wr_rld_lo (cfg_we && (cfg_addr == RG_RLD_LO)),
    .wr_rld_hi (cfg_we && (cfg_addr == RG_RLD_HI)),
    .wr_cnt_lo (cfg_we && (cfg_addr == RG_CNT_LO)),
    .wr_cnt_hi (cfg_we && (cfg_addr == RG_CNT_HI)),
    .wdata     (cfg_wdata),
    .cnt       (pmc_value),
    .wrap_req  (wrap_req)
  );

  assign br_irq    = ch_irq[CH_BR];
  assign smp_irq   = ch_irq[CH_SMP];
  assign br_ovf    = ch_ovf[CH_BR];
  assign smp_ovf   = ch_ovf[CH_SMP];
  assign cfg_err   = cfg_err_q;
  assign br_index  = ch_idx[CH_BR];
  assign smp_index = ch_idx[CH_SMP];

  // R4: every beat lies wholly below the active channel's limit
  a_r4_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> rec_fits(mem_addr, seq_is_smp ? ch_lim[CH_SMP] : ch_lim[CH_BR], BEAT_BYTES));
  // R8: with both waiting at an idle point, no branch record starts next
  a_r8_smp_first: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && smp_pend_q && idle) |=> !(seq_busy && !seq_is_smp));
  // R7: a branch record only starts while branch storing was enabled
  a_r7_br_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_valid) && !seq_is_smp) |-> $past(en_q[CH_BR]));
  // R9: a misaligned base write raises the configuration error
  a_r9_bad_base: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == chan_reg(CH_BR, 0) || cfg_addr == chan_reg(CH_SMP, 0))
     && (cfg_wdata[1:0] != 2'b00)) |=> cfg_err_q);
endmodule

// File: tb/test_trace_store_engine.sv
module test_trace_store_engine;
  import trs_pkg::*;
  localparam int CNT_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [REG_AW-1:0] cfg_addr = '0;
  logic [DW-1:0]     cfg_wdata = '0;
  logic              br_valid = 1'b0;
  logic              br_ready;
  logic [DW-1:0]     br_from = '0, br_to = '0;
  logic              pmc_evt = 1'b0;
  logic [CNT_W-1:0]  pmc_value;
  logic              mem_valid, mem_ready;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic              br_irq, smp_irq, br_ovf, smp_ovf, cfg_err;
  logic [AW-1:0]     br_index, smp_index;

  trace_store_engine #(.CNT_W(CNT_W)) i_trace_store_engine (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit hold_mem = 1'b0;

  addr_t q_addr[$];
  word_t q_data[$];
  string q_tag[$];

  addr_t m_idx[2], m_lim[2], m_thr[2];
  bit    m_irq[2], m_ovf[2], m_en[2];
  logic [CNT_W-1:0] m_rld;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  // memory side: random ready, log each beat that the next edge accepts
  initial begin
    mem_ready = 1'b0;
    forever begin
      @(negedge clk);
      mem_ready = !hold_mem && ($urandom_range(0, 99) < 65);
      #1;
      if (rst_n && mem_valid && mem_ready) begin
        if (q_addr.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R4 unexpected write: actual %0h expected none", mem_addr);
        end else begin
          chk(q_tag[0], "beat address", mem_addr, q_addr[0]);
          chk(q_tag[0], "beat data", mem_wdata, q_data[0]);
          void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  function automatic bit fits_m(addr_t i, addr_t l, int n);
    return ({32'h0, i} + 64'(n)) <= {32'h0, l};
  endfunction

  // expected effect of one record on channel c
  function automatic void model_store(int c, word_t from, word_t to);
    int n = (c == 1) ? 40 : 12;
    if (fits_m(m_idx[c], m_lim[c], n)) begin
      for (int k = 0; k < n / 4; k++) begin
        q_addr.push_back(m_idx[c] + addr_t'(4 * k));
        if (c == 1) q_data.push_back(word_t'(k));
        else q_data.push_back(k == 0 ? from : (k == 1 ? to : 32'h0));
        q_tag.push_back(c == 1 ? "R2" : "R1");
      end
      m_idx[c] = m_idx[c] + addr_t'(n);
      if (m_idx[c] == m_thr[c]) m_irq[c] = 1'b1;
    end else m_ovf[c] = 1'b1;
  endfunction

  task automatic cfg(input logic [3:0] a, input word_t d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_chan(input int c, input addr_t base, input addr_t lim, input addr_t thr);
    cfg(4'(4 * c), base); cfg(4'(4 * c + 2), lim); cfg(4'(4 * c + 3), thr);
    m_idx[c] = base; m_lim[c] = lim; m_thr[c] = thr;
  endtask

  task automatic set_en(input bit b, input bit s);
    cfg(4'd12, {30'h0, s, b});
    m_en[0] = b; m_en[1] = s;
  endtask

  task automatic clear(input word_t mask);
    cfg(4'd13, mask);
    if (mask[0]) m_irq[0] = 1'b0;
    if (mask[1]) m_irq[1] = 1'b0;
    if (mask[2]) m_ovf[0] = 1'b0;
    if (mask[3]) m_ovf[1] = 1'b0;
  endtask

  task automatic drain();
    while (q_addr.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_branch(input word_t from, input word_t to);
    @(negedge clk);
    br_valid = 1'b1; br_from = from; br_to = to;
    #1;
    while (!br_ready) begin @(negedge clk); #1; end
    if (m_en[0]) model_store(0, from, to);
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic fire_overflow();
    cfg(4'd10, 32'hFFFF_FFFF);
    cfg(4'd11, 32'h0000_00FF);
    @(negedge clk); pmc_evt = 1'b1;
    @(negedge clk); pmc_evt = 1'b0;
    if (m_en[1]) model_store(1, '0, '0);
  endtask

  task automatic check_state(input string tag);
    chk(tag, "br_index", br_index, m_idx[0]);
    chk(tag, "smp_index", smp_index, m_idx[1]);
    chk(tag, "br_irq", br_irq, m_irq[0]);
    chk(tag, "smp_irq", smp_irq, m_irq[1]);
    chk(tag, "br_ovf", br_ovf, m_ovf[0]);
    chk(tag, "smp_ovf", smp_ovf, m_ovf[1]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11", "mem_valid", mem_valid, 0);
    chk("R11", "br_ready", br_ready, 1);
    chk("R11", "br_index", br_index, 0);
    chk("R11", "pmc_value", pmc_value, 0);
    chk("R11", "flags", {br_irq, smp_irq, br_ovf, smp_ovf, cfg_err}, 0);

    // R10 base write loads index
    set_chan(0, 32'h1000, 32'h1048, 32'h1030);
    set_chan(1, 32'h2000, 32'h20A0, 32'h2050);
    chk("R10", "index after base write", br_index, 32'h1000);
    m_rld = 40'h12_3456_7890;
    cfg(4'd8, 32'h3456_7890); cfg(4'd9, 32'h12);
    set_en(1, 1);

    // R9 misaligned base rejected
    cfg(4'd0, 32'h1002);
    @(negedge clk);
    chk("R9", "cfg_err", cfg_err, 1);
    chk("R9", "index kept", br_index, 32'h1000);
    clear(32'h10);
    chk("R9", "cfg_err cleared", cfg_err, 0);

    // R7 branch disabled
    set_en(0, 1);
    send_branch(32'hDEAD_0001, 32'hDEAD_0002);
    drain();
    chk("R7", "index with branch disabled", br_index, 32'h1000);
    set_en(1, 1);

    // R1 / R5 / R4 branch ring walk
    for (int i = 0; i < 3; i++) send_branch($urandom, $urandom);
    drain();
    chk("R5", "no irq before threshold", br_irq, 0);
    send_branch($urandom, $urandom);
    drain();
    chk("R5", "irq at threshold", br_irq, 1);
    chk("R1", "index at threshold", br_index, 32'h1030);
    send_branch($urandom, $urandom);
    send_branch($urandom, $urandom);
    drain();
    chk("R5", "irq held past threshold", br_irq, 1);
    chk("R4", "index at limit", br_index, 32'h1048);
    send_branch(32'hBAD0_0000, 32'hBAD0_0001);
    drain();
    chk("R4", "overflow set", br_ovf, 1);
    chk("R4", "index kept at limit", br_index, 32'h1048);
    clear(32'h5);
    chk("R5", "irq cleared", br_irq, 0);
    chk("R4", "overflow cleared", br_ovf, 0);

    // R2 / R6 sampling records
    fire_overflow();
    drain();
    chk("R6", "counter reloaded", pmc_value, m_rld);
    chk("R2", "sampling index", smp_index, 32'h2028);
    fire_overflow();
    drain();
    chk("R5", "sampling irq", smp_irq, 1);

    // R7 sampling disabled: wrap only
    set_en(1, 0);
    fire_overflow();
    drain();
    chk("R7", "counter wrapped to zero", pmc_value, 0);
    chk("R7", "sampling index kept", smp_index, 32'h2050);
    set_en(1, 1);

    // R8 / R3 priority under a stalled port
    cfg(4'd1, 32'h1000); m_idx[0] = 32'h1000;
    chk("R10", "index direct write", br_index, 32'h1000);
    hold_mem = 1'b1;
    send_branch(32'hA000_0001, 32'hA000_0002);
    fire_overflow();
    fork send_branch(32'hB000_0001, 32'hB000_0002); join_none
    repeat (5) @(negedge clk);
    #1;
    chk("R3", "index held mid-record", br_index, 32'h1000);
    chk("R3", "beat held while stalled", mem_addr, 32'h1000);
    chk("R8", "branch held back", br_ready, 0);
    hold_mem = 1'b0;
    wait fork;
    drain();
    chk("R6", "counter after priority record", pmc_value, m_rld);
    check_state("R8");

    // random mix
    clear(32'h1F);
    set_chan(0, 32'h4000, 32'h4000 + 12 * 20, 32'h4000 + 12 * 15);
    set_chan(1, 32'h8000, 32'h8000 + 40 * 6, 32'h8000 + 40 * 3);
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        drain();
        fire_overflow();
      end else send_branch($urandom, $urandom);
      if ($urandom_range(0, 4) == 0) drain();
    end
    drain();
    check_state("R4");
    chk("R6", "counter after random mix", pmc_value, m_rld);
    chk("R4", "no beats left over", q_addr.size(), 0);

    summary();
    $finish;
  end
endmodule